// File: doc/BRIEF.md
# Dual-Processor Mailbox Port

This block lets two processors pass bytes to each other through one shared 8-bit port. The master side sits on a simple synchronous register interface. It can post a byte for the slave, read the byte that the slave left, and read a two-bit status word. The slave side is wired to the port pins and to three active-low strobes: chip select, read and write. These strobes are asynchronous to the system clock, so the block synchronises them before it decodes anything.

When the slave reads, the block drives the port with either the posted byte or the status word. The slave's address line chooses which one. When the slave writes, the block captures the byte on the port as the write strobe is released. Each direction has a full flag. Writing a byte into that direction sets its flag. The other side clears the flag by reading the data, which gives both processors a simple handshake.

Top module: `mbx_port`

## Requirements
- R1: After a synchronous reset, both data registers read zero, both full flags read zero and the port output enable is low.
- R2: A master write with `m_addr` = 0 loads `m_wdata` into the outbound register and sets the outbound full flag (status bit 0).
- R3: While the synchronised chip select and read strobe are both low and the write strobe is high, `port_oe` is high. During that time `port_o` carries the outbound register when `s_addr` = 0, or the status word when `s_addr` = 1. `port_oe` is low at all other times.
- R4: `port_oe` stays low whenever the synchronised write strobe and chip select are both low, even if the read strobe is also low. This prevents contention with the slave's write data.
- R5: When the slave-write term (chip select low and write low) is released, `port_i` is captured into the inbound register and the inbound full flag (status bit 1) is set. A master read with `m_addr` = 0 returns that register.
- R6: A write strobe pulse while chip select is high has no effect: the inbound register and the inbound flag stay unchanged.
- R7: A completed slave read with `s_addr` = 0 clears the outbound full flag. A slave read with `s_addr` = 1 leaves the flag unchanged.
- R8: A master read with `m_addr` = 0 clears the inbound full flag. A master read with `m_addr` = 1 leaves it unchanged.
- R9: If a flag is set and cleared in the same clock cycle, the set wins.
- R10: A master write with `m_addr` = 1 changes neither the outbound register nor any flag.
- R11: The status word reads the same from both sides: bit 0 is the outbound flag, bit 1 is the inbound flag, and the upper bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| m_we | input | 1 | Master write pulse, one cycle |
| m_re | input | 1 | Master read pulse, one cycle |
| m_addr | input | 1 | Master select: 0 = data, 1 = status |
| m_wdata | input | 8 | Master write data |
| m_rdata | output | 8 | Master read data (inbound register or status) |
| s_cs_n | input | 1 | Slave chip select, active low, asynchronous |
| s_rd_n | input | 1 | Slave read strobe, active low, asynchronous |
| s_wr_n | input | 1 | Slave write strobe, active low, asynchronous |
| s_addr | input | 1 | Slave select: 0 = data, 1 = status |
| port_i | input | 8 | Value seen on the shared port pins |
| port_o | output | 8 | Value driven onto the shared port |
| port_oe | output | 1 | Port driver enable |

## Verification
A stuck or wrongly set full flag shows up in the status word on the very next master status read. It also shows on the port during the slave's next status read, which comes within three clocks of that read strobe falling. A corrupted data register shows up as a wrong byte on the first transfer in that direction. Sweeping all 256 byte values in both directions therefore exposes any bit that is dropped or swapped. A wrong decode of the strobes shows up as `port_oe` asserting during a write or a chip-deselected cycle. It also shows up as a capture that either never happens or happens when it should not.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic {
        SEL_DATA = 1'b0,
        SEL_STAT = 1'b1
    } mbx_sel_e;

    typedef struct packed {
        logic s2m_full;
        logic m2s_full;
    } mbx_flags_t;

    typedef struct packed {
        logic rd_term;
        logic wr_term;
        logic rd_done;
        logic wr_done;
    } slv_evt_t;

    localparam int unsigned STROBE_CNT = 3;
    localparam int unsigned STRB_CS    = 0;
    localparam int unsigned STRB_RD    = 1;
    localparam int unsigned STRB_WR    = 2;

    function automatic logic [1:0] flags_bits(input mbx_flags_t f);
        return {f.s2m_full, f.m2s_full};
    endfunction

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic [WIDTH-1:0] stg;
            always_ff @(posedge clk) begin
                if (rst) stg <= RST_VAL;
                else     stg <= d;
            end
            assign q = stg;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] stg;
            always_ff @(posedge clk) begin
                if (rst) stg <= {STAGES{RST_VAL}};
                else     stg <= {stg[STAGES-2:0], d};
            end
            assign q = stg[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/mbx_slave_decode.sv
module mbx_slave_decode
    import mbx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [STROBE_CNT-1:0] strb_n,
    input  logic                  s_addr,
    output slv_evt_t              evt
);
    logic rd_term, wr_term, rd_q, wr_q;
    mbx_sel_e sel_q;

    assign rd_term = !strb_n[STRB_CS] && !strb_n[STRB_RD] && strb_n[STRB_WR];
    assign wr_term = !strb_n[STRB_CS] && !strb_n[STRB_WR];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= 1'b0;
            wr_q  <= 1'b0;
            sel_q <= SEL_DATA;
        end else begin
            rd_q <= rd_term;
            wr_q <= wr_term;
            if (rd_term) sel_q <= mbx_sel_e'(s_addr);
        end
    end

    always_comb begin
        evt.rd_term = rd_term;
        evt.wr_term = wr_term;
        evt.rd_done = rd_q && !rd_term && (sel_q == SEL_DATA);
        evt.wr_done = wr_q && !wr_term;
    end
endmodule

// File: rtl/mbx_regs.sv
module mbx_regs
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              m_we,
    input  logic              m_re,
    input  logic              m_addr,
    input  logic [DATA_W-1:0] m_wdata,
    input  slv_evt_t          evt,
    input  logic [DATA_W-1:0] port_i,
    output logic [DATA_W-1:0] out_reg,
    output logic [DATA_W-1:0] in_reg,
    output mbx_flags_t        flags
);
    logic m_wr_data, m_rd_data;

    assign m_wr_data = m_we && (mbx_sel_e'(m_addr) == SEL_DATA);
    assign m_rd_data = m_re && (mbx_sel_e'(m_addr) == SEL_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_reg <= '0;
            in_reg  <= '0;
            flags   <= '0;
        end else begin
            if (m_wr_data)   out_reg <= m_wdata;
            if (evt.wr_done) in_reg  <= port_i;

            if (m_wr_data)        flags.m2s_full <= 1'b1;
            else if (evt.rd_done) flags.m2s_full <= 1'b0;

            if (evt.wr_done)      flags.s2m_full <= 1'b1;
            else if (m_rd_data)   flags.s2m_full <= 1'b0;
        end
    end
endmodule

// File: rtl/mbx_port.sv
module mbx_port
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              m_we,
    input  logic              m_re,
    input  logic              m_addr,
    input  logic [DATA_W-1:0] m_wdata,
    output logic [DATA_W-1:0] m_rdata,
    input  logic              s_cs_n,
    input  logic              s_rd_n,
    input  logic              s_wr_n,
    input  logic              s_addr,
    input  logic [DATA_W-1:0] port_i,
    output logic [DATA_W-1:0] port_o,
    output logic              port_oe
);
    localparam int unsigned PAD_W = DATA_W - 2;

    logic [STROBE_CNT-1:0] strb_raw, strb_s;
    slv_evt_t              evt;
    logic [DATA_W-1:0]     out_reg, in_reg, stat_word;
    mbx_flags_t            flags;

    always_comb begin
        strb_raw           = '1;
        strb_raw[STRB_CS]  = s_cs_n;
        strb_raw[STRB_RD]  = s_rd_n;
        strb_raw[STRB_WR]  = s_wr_n;
    end

    mbx_sync #(
        .WIDTH   (STROBE_CNT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({STROBE_CNT{1'b1}})
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (strb_raw),
        .q   (strb_s)
    );

    mbx_slave_decode u_dec (
        .clk    (clk),
        .rst    (rst),
        .strb_n (strb_s),
        .s_addr (s_addr),
        .evt    (evt)
    );

    mbx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .m_we    (m_we),
        .m_re    (m_re),
        .m_addr  (m_addr),
        .m_wdata (m_wdata),
        .evt     (evt),
        .port_i  (port_i),
        .out_reg (out_reg),
        .in_reg  (in_reg),
        .flags   (flags)
    );

    assign stat_word = {{PAD_W{1'b0}}, flags_bits(flags)};
    assign m_rdata   = (mbx_sel_e'(m_addr) == SEL_STAT) ? stat_word : in_reg;
    assign port_o    = (mbx_sel_e'(s_addr) == SEL_STAT) ? stat_word : out_reg;
    assign port_oe   = evt.rd_term;
endmodule

// File: rtl/mbx_port_chk.sv
module mbx_port_chk
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              m_we,
    input logic              m_re,
    input logic              m_addr,
    input logic              port_oe,
    input slv_evt_t          evt,
    input mbx_flags_t        flags,
    input logic [DATA_W-1:0] out_reg
);
    // R4
    oe_no_contend_chk: assert property (@(posedge clk) disable iff (rst)
        port_oe |-> !evt.wr_term);

    // R2
    m2s_set_chk: assert property (@(posedge clk) disable iff (rst)
        (m_we && m_addr == 1'b0) |=> flags.m2s_full);

    // R7
    m2s_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.rd_done && !(m_we && m_addr == 1'b0)) |=> !flags.m2s_full);

    // R5
    s2m_set_chk: assert property (@(posedge clk) disable iff (rst)
        evt.wr_done |=> flags.s2m_full);

    // R8
    s2m_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (m_re && m_addr == 1'b0 && !evt.wr_done) |=> !flags.s2m_full);

    // R10
    stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (m_we && m_addr == 1'b1) |=> $stable(out_reg));
endmodule

bind mbx_port mbx_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .m_we    (m_we),
    .m_re    (m_re),
    .m_addr  (m_addr),
    .port_oe (port_oe),
    .evt     (evt),
    .flags   (flags),
    .out_reg (out_reg)
);

// File: tb/sim_mbx_port.sv
`timescale 1ns/1ps
module sim_mbx_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_we = 1'b0, m_re = 1'b0, m_addr = 1'b0;
    logic [7:0] m_wdata = '0, m_rdata;
    logic       s_cs_n = 1'b1, s_rd_n = 1'b1, s_wr_n = 1'b1, s_addr = 1'b0;
    logic [7:0] port_i = '0, port_o;
    logic       port_oe;

    int vectors = 0;
    int fails   = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    mbx_port u0 (
        .clk(clk), .rst(rst), .m_we(m_we), .m_re(m_re), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_rdata(m_rdata), .s_cs_n(s_cs_n), .s_rd_n(s_rd_n),
        .s_wr_n(s_wr_n), .s_addr(s_addr), .port_i(port_i), .port_o(port_o),
        .port_oe(port_oe)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic m_write(input logic a, input logic [7:0] d);
        @(negedge clk); m_we = 1'b1; m_addr = a; m_wdata = d;
        @(negedge clk); m_we = 1'b0;
    endtask

    task automatic m_read(input logic a, output logic [7:0] d);
        @(negedge clk); m_re = 1'b1; m_addr = a;
        #1 d = m_rdata;
        @(negedge clk); m_re = 1'b0;
    endtask

    task automatic s_read(input logic a, output logic oe, output logic [7:0] d);
        @(negedge clk); s_addr = a; s_cs_n = 1'b0; s_rd_n = 1'b0;
        repeat (3) @(negedge clk);
        oe = port_oe; d = port_o;
        s_rd_n = 1'b1; s_cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic s_write(input logic [7:0] d, input logic use_cs);
        @(negedge clk); port_i = d; s_cs_n = !use_cs; s_wr_n = 1'b0;
        repeat (3) @(negedge clk);
        s_wr_n = 1'b1;
        repeat (4) @(negedge clk);
        s_cs_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic oe;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1 chk(port_oe == 1'b0, "R1 oe", port_oe, 0);
        m_read(1'b1, d); chk(d == 8'h00, "R1 status", d, 0);
        m_read(1'b0, d); chk(d == 8'h00, "R1 inbound", d, 0);
        s_read(1'b0, oe, d); chk(d == 8'h00, "R1 outbound", d, 0);

        // R2 R3 R7 R11: master to slave sweep
        for (int v = 0; v < 256; v++) begin
            m_write(1'b0, 8'(v));
            m_read(1'b1, d); chk(d == 8'h01, "R2 flag set", d, 1);
            s_read(1'b0, oe, d);
            chk(oe == 1'b1, "R3 oe", oe, 1);
            chk(d == 8'(v), "R3 data", d, v);
            m_read(1'b1, d); chk(d == 8'h00, "R7 flag clear", d, 0);
        end

        // R5 R8 R11: slave to master sweep
        for (int v = 0; v < 256; v++) begin
            s_write(8'(v ^ 8'hA5), 1'b1);
            s_read(1'b1, oe, d); chk(d == 8'h02, "R11 slave status", d, 2);
            m_read(1'b1, d); chk(d == 8'h02, "R5 flag set", d, 2);
            m_read(1'b1, d); chk(d == 8'h02, "R8 status read keeps", d, 2);
            m_read(1'b0, d); chk(d == 8'(v ^ 8'hA5), "R5 data", d, v ^ 8'hA5);
            m_read(1'b1, d); chk(d == 8'h00, "R8 flag clear", d, 0);
        end

        // R3: read strobe without chip select
        @(negedge clk); s_rd_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(port_oe == 1'b0, "R3 no cs", port_oe, 0);
        s_rd_n = 1'b1;
        repeat (4) @(negedge clk);

        // R4: read and write both low
        @(negedge clk); port_i = 8'h3C; s_cs_n = 1'b0; s_rd_n = 1'b0; s_wr_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(port_oe == 1'b0, "R4 oe during write", port_oe, 0);
        s_wr_n = 1'b1; s_rd_n = 1'b1; s_cs_n = 1'b1;
        repeat (4) @(negedge clk);
        m_read(1'b0, d); chk(d == 8'h3C, "R4 capture", d, 8'h3C);

        // R6: write without chip select ignored
        s_write(8'hE7, 1'b0);
        m_read(1'b1, d); chk(d == 8'h00, "R6 flag", d, 0);
        m_read(1'b0, d); chk(d == 8'h3C, "R6 data", d, 8'h3C);

        // R7: slave status read keeps outbound flag
        m_write(1'b0, 8'h96);
        s_read(1'b1, oe, d); chk(d == 8'h01, "R7 status via port", d, 1);
        m_read(1'b1, d); chk(d == 8'h01, "R7 flag kept", d, 1);

        // R10: master write to status ignored
        m_write(1'b1, 8'hFF);
        m_read(1'b1, d); chk(d == 8'h01, "R10 flags", d, 1);
        s_read(1'b0, oe, d); chk(d == 8'h96, "R10 data", d, 8'h96);

        // R9: outbound set and clear in the same cycle
        m_write(1'b0, 8'h11);
        @(negedge clk); s_addr = 1'b0; s_cs_n = 1'b0; s_rd_n = 1'b0;
        repeat (3) @(negedge clk);
        s_rd_n = 1'b1; s_cs_n = 1'b1;
        @(negedge clk);
        @(negedge clk); m_we = 1'b1; m_addr = 1'b0; m_wdata = 8'h22;
        @(negedge clk); m_we = 1'b0;
        m_read(1'b1, d); chk(d == 8'h01, "R9 outbound set wins", d, 1);
        s_read(1'b0, oe, d); chk(d == 8'h22, "R9 outbound data", d, 8'h22);

        // R9: inbound set and clear in the same cycle
        @(negedge clk); port_i = 8'h33; s_cs_n = 1'b0; s_wr_n = 1'b0;
        repeat (3) @(negedge clk);
        s_wr_n = 1'b1;
        @(negedge clk);
        @(negedge clk); m_re = 1'b1; m_addr = 1'b0;
        @(negedge clk); m_re = 1'b0; s_cs_n = 1'b1;
        m_read(1'b1, d); chk(d == 8'h02, "R9 inbound set wins", d, 2);
        m_read(1'b0, d); chk(d == 8'h33, "R9 inbound data", d, 8'h33);

        // R1: reset again clears everything
        m_write(1'b0, 8'h5A);
        s_write(8'h6B, 1'b1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1 chk(port_oe == 1'b0, "R1 oe after reset", port_oe, 0);
        m_read(1'b1, d); chk(d == 8'h00, "R1 flags after reset", d, 0);
        m_read(1'b0, d); chk(d == 8'h00, "R1 inbound after reset", d, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule